// File: doc/BRIEF.md
# Third-Order Fractional Interpolator for a Fractional-N Divider

This block produces the per-cycle divide offset of a fractional-N frequency synthesizer. Once per phase-detector reference cycle it emits a small signed integer that the divider adds to its integer ratio N. Over time the offsets average to FRAC/MOD, so the mean ratio is N + FRAC/MOD. FRAC is a 12-bit numerator and MOD is a 12-bit modulus that can take any value, not only a power of two.

Three first-order accumulators are chained, and each one wraps modulo MOD. Their carries are recombined with first and second differences, which pushes quantization noise to high offset frequencies. A 21-bit pseudo-random source can add one bit per cycle into the first stage. This breaks up the short repeat patterns that appear as fractional spurs, at the cost of a broadband noise floor. The moduli that are too small for dither simply run without it.

Software captures the configuration with a one-cycle load strobe. The strobe also returns every accumulator, delay stage and the random source to a known starting state.

Top module: `mash_sdm`

## Requirements
- R1: `offset_out` is a 4-bit two's-complement value and always lies between -3 and +4 inclusive.
- R2: A clock edge with `load` high captures `frac_in`, `mod_in` and `dither_en`, clears all internal state and drives `offset_out` to 0. The first offset computed with the new settings appears after the next clock edge that has `load` low.
- R3: Each accumulator holds a residue below the active modulus. A `mod_in` below 2 is taken as 2. FRAC is expected below MOD.
- R4: Each cycle, stage 1 adds FRAC plus the dither bit to its residue, and stages 2 and 3 each add the new residue of the stage before. A sum at or above MOD raises that stage's carry (c1, c2, c3) and has MOD subtracted. The next registered offset is c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where ' means one cycle earlier and '' means two cycles earlier.
- R5: With FRAC = 0 and dither off, `offset_out` is 0 in every cycle.
- R6: With dither off, the offset sequence after a load repeats with a period L. L is 6·MOD when MOD is divisible by 6, 2·MOD when MOD is even but not a multiple of 3, 3·MOD when MOD is a multiple of 3 but odd, and MOD otherwise.
- R7: With dither off, the offsets summed over any L consecutive cycles equal FRAC·L/MOD.
- R8: With dither on, the added bit is bit 20 of a 21-bit shift register. The register is seeded to 1 on load and shifts left each cycle, with the new bit 0 being bit 20 XOR bit 18. Its period is 2^21 − 1, so the output no longer follows the short dither-off pattern.
- R9: A dither request with an effective MOD below 50 is ignored. The output then matches the dither-off sequence exactly.
- R10: `frac_in`, `mod_in` and `dither_en` have no effect while `load` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture configuration and restart the sequence |
| frac_in | input | 12 | Fractional numerator |
| mod_in | input | 12 | Modulus |
| dither_en | input | 1 | Request pseudo-random dither |
| offset_out | output | 4 | Signed divide offset for this cycle |

## Verification
The bench targets moduli in each divisibility class, and it records two full periods to confirm both the repeat length and the exact offset sum. A wrap done at a power of two, or a lost carry, would break the sum. A missing delay in the difference network would change the exact sequence that a bench model, built from the cascade equation, predicts. The bench also covers the largest modulus with FRAC = MOD − 1, where stage 1 sees its biggest input, and a modulus below 2 to exercise clamping. The dither guard is tested at a modulus of 40, where a design that let dither through would depart from the plain sequence. It is also tested at 100, where a dead random source would make the sequence identical to the plain one. Changing the configuration inputs without a load catches a design that samples them outside the strobe.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
    localparam int STAGES     = 3;
    localparam int RND_W      = 21;
    localparam int RND_TAP    = 18;
    localparam int OFS_W      = 4;
endpackage

// File: rtl/sdm_mod_acc.sv
module sdm_mod_acc #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] modv,
    input  logic [W:0]   din,
    output logic         carry,
    output logic [W-1:0] resid
);
    logic [W-1:0] acc_d, acc_q;
    logic [W:0]   sum;
    logic [W:0]   wrapped;

    always_comb begin
        sum     = {1'b0, acc_q} + din;
        wrapped = sum - {1'b0, modv};
        carry   = (sum >= {1'b0, modv});
        resid   = carry ? wrapped[W-1:0] : sum[W-1:0];
        acc_d   = clr ? '0 : resid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R3: stored residue never reaches the modulus
    p_resid_below_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < modv);
endmodule

// File: rtl/sdm_rnd.sv
module sdm_rnd
    import sdm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic bit_out
);
    logic [RND_W-1:0] sr_d, sr_q;

    always_comb begin
        bit_out = sr_q[RND_W-1];
        sr_d    = {sr_q[RND_W-2:0], sr_q[RND_W-1] ^ sr_q[RND_TAP]};
        if (clr) sr_d = RND_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= RND_W'(1);
        else        sr_q <= sr_d;
    end

    // R8: the shift register never falls into the all-zero lock state
    p_rnd_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0);
endmodule

// File: rtl/sdm_shaper.sv
module sdm_shaper
    import sdm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [STAGES-1:0]       carry,
    output logic signed [OFS_W-1:0] y
);
    typedef struct packed {
        logic [OFS_W-1:0] y;
        logic             c2z;
        logic             c3z1;
        logic             c3z2;
    } shp_t;

    shp_t st_d, st_q;

    always_comb begin
        st_d.y    = {3'b000, carry[0]}
                  + {3'b000, carry[1]} - {3'b000, st_q.c2z}
                  + {3'b000, carry[2]} - {2'b00, st_q.c3z1, 1'b0}
                  + {3'b000, st_q.c3z2};
        st_d.c2z  = carry[1];
        st_d.c3z1 = carry[2];
        st_d.c3z2 = st_q.c3z1;
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y = $signed(st_q.y);

    // R1: offset stays in the third-order cascade range
    p_out_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (y >= -4'sd3) && (y <= 4'sd4));
    // R2: a load edge leaves a zero offset behind it
    p_load_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (y == 4'sd0));
endmodule

// File: rtl/mash_sdm.sv
module mash_sdm
    import sdm_pkg::*;
#(
    parameter int W          = 12,
    parameter int DITHER_MIN = 50
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [W-1:0]            frac_in,
    input  logic [W-1:0]            mod_in,
    input  logic                    dither_en,
    output logic signed [OFS_W-1:0] offset_out
);
    typedef struct packed {
        logic [W-1:0] frac;
        logic [W-1:0] modv;
        logic         dith;
    } cfg_t;

    cfg_t         cfg_d, cfg_q;
    logic [W-1:0] mod_clamped;
    logic         rnd_bit;
    logic [W:0]   stage_in [STAGES];
    logic [W-1:0] resid    [STAGES];
    logic [STAGES-1:0] carry;

    always_comb begin
        mod_clamped = (mod_in < W'(2)) ? W'(2) : mod_in;
        cfg_d       = cfg_q;
        if (load) begin
            cfg_d.frac = frac_in;
            cfg_d.modv = mod_clamped;
            cfg_d.dith = dither_en && (mod_clamped >= W'(DITHER_MIN));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{frac: '0, modv: W'(2), dith: 1'b0};
        else        cfg_q <= cfg_d;
    end

    sdm_rnd u_rnd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (load),
        .bit_out (rnd_bit)
    );

    assign stage_in[0] = {1'b0, cfg_q.frac} + {{W{1'b0}}, (cfg_q.dith & rnd_bit)};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g > 0) begin : g_chain
            assign stage_in[g] = {1'b0, resid[g-1]};
        end
        sdm_mod_acc #(.W(W)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (load),
            .modv  (cfg_q.modv),
            .din   (stage_in[g]),
            .carry (carry[g]),
            .resid (resid[g])
        );
    end

    sdm_shaper u_shp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .carry (carry),
        .y     (offset_out)
    );

    // R9: dither is only active with a large enough modulus
    p_dither_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.dith |-> (cfg_q.modv >= W'(DITHER_MIN)));
    // R5: zero numerator without dither gives integer-N behaviour
    p_zero_frac_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_q.frac == '0) && !cfg_q.dith) |-> (offset_out == 4'sd0));
    // R3: modulus held in the configuration is never below 2
    p_mod_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.modv >= W'(2));
endmodule

// File: tb/mash_sdm_test.sv
module mash_sdm_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic [11:0] frac_in = '0;
    logic [11:0] mod_in = 12'd2;
    logic dither_en = 1'b0;
    logic signed [3:0] offset_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_frac, m_mod, m_dith, m_a1, m_a2, m_a3, m_c2z, m_c3z1, m_c3z2, m_out, m_sr;
    int rec [0:8191];
    int alt [0:8191];

    mash_sdm uut (
        .clk(clk), .rst_n(rst_n), .load(load), .frac_in(frac_in),
        .mod_in(mod_in), .dither_en(dither_en), .offset_out(offset_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_a1 = 0; m_a2 = 0; m_a3 = 0; m_c2z = 0; m_c3z1 = 0; m_c3z2 = 0;
        m_out = 0; m_sr = 1;
    endtask

    task automatic model_step();
        int din, s, c1, c2, c3, b;
        b   = (m_sr >> 20) & 1;
        din = m_frac + (m_dith ? b : 0);
        s = m_a1 + din;  c1 = (s >= m_mod); m_a1 = c1 ? s - m_mod : s;
        s = m_a2 + m_a1; c2 = (s >= m_mod); m_a2 = c2 ? s - m_mod : s;
        s = m_a3 + m_a2; c3 = (s >= m_mod); m_a3 = c3 ? s - m_mod : s;
        m_out  = c1 + c2 - m_c2z + c3 - 2 * m_c3z1 + m_c3z2;
        m_c2z  = c2;
        m_c3z2 = m_c3z1;
        m_c3z1 = c3;
        m_sr   = ((m_sr << 1) & 32'h1FFFFF) | (b ^ ((m_sr >> 18) & 1));
    endtask

    // one clock: update model per the strobe level, compare after the edge
    task automatic tick(input string req);
        @(posedge clk);
        if (load) begin
            m_frac = int'(frac_in);
            m_mod  = (mod_in < 2) ? 2 : int'(mod_in);
            m_dith = (dither_en && m_mod >= 50) ? 1 : 0;
            model_clear();
        end else begin
            model_step();
        end
        @(negedge clk);
        chk(int'(offset_out) == m_out, req, int'(offset_out), m_out);
        chk(int'(offset_out) >= -3 && int'(offset_out) <= 4, "R1", int'(offset_out), 0);
    endtask

    task automatic do_load(input int f, input int m, input bit d);
        frac_in = 12'(f); mod_in = 12'(m); dither_en = d; load = 1'b1;
        tick("R2");
        chk(offset_out == 0, "R2", int'(offset_out), 0);
        load = 1'b0;
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            tick(req);
            if (i < 8192) rec[i] = int'(offset_out);
        end
    endtask

    function automatic int period_of(input int m);
        if (m % 6 == 0) return 6 * m;
        if (m % 2 == 0) return 2 * m;
        if (m % 3 == 0) return 3 * m;
        return m;
    endfunction

    task automatic period_test(input int f, input int m);
        int len, sum, eff;
        eff = (m < 2) ? 2 : m;
        len = period_of(eff);
        do_load(f, m, 1'b0);
        run(2 * len, "R4");
        for (int i = 0; i < len; i++)
            chk(rec[i] == rec[i + len], "R6", rec[i + len], rec[i]);
        sum = 0;
        for (int i = 3; i < len + 3; i++) sum += rec[i];
        chk(sum == f * len / eff, "R7", sum, f * len / eff);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(offset_out == 0, "R2", int'(offset_out), 0);
        rst_n = 1'b1;
        m_frac = 0; m_mod = 2; m_dith = 0; model_clear();
        run(20, "R5");

        // R5: zero numerator, integer-N
        do_load(0, 1000, 1'b0);
        run(500, "R5");
        for (int i = 0; i < 500; i++) chk(rec[i] == 0, "R5", rec[i], 0);

        // R6/R7 over each divisibility class
        period_test(3, 7);
        period_test(7, 10);
        period_test(4, 9);
        period_test(5, 12);
        period_test(1, 0);      // R3: clamp to modulus 2

        // R3/R4: largest modulus, largest numerator
        do_load(4094, 4095, 1'b0);
        run(3000, "R4");

        // R10: config changes without load are ignored
        do_load(17, 60, 1'b0);
        frac_in = 12'd5; mod_in = 12'd3; dither_en = 1'b1;
        run(400, "R10");

        // R9: dither request below the floor is ignored
        do_load(13, 40, 1'b0);
        run(600, "R9");
        for (int i = 0; i < 600; i++) alt[i] = rec[i];
        do_load(13, 40, 1'b1);
        run(600, "R9");
        for (int i = 0; i < 600; i++) chk(rec[i] == alt[i], "R9", rec[i], alt[i]);

        // R8: dither active above the floor changes the pattern
        begin
            int diff;
            do_load(37, 100, 1'b0);
            run(2000, "R4");
            for (int i = 0; i < 2000; i++) alt[i] = rec[i];
            do_load(37, 100, 1'b1);
            run(2000, "R8");
            diff = 0;
            for (int i = 0; i < 2000; i++) if (rec[i] != alt[i]) diff++;
            chk(diff > 0, "R8", diff, 1);
        end

        // random configurations
        void'($urandom(32'd4242));
        for (int k = 0; k < 6; k++) begin
            int m, f;
            m = 2 + int'($urandom % 599);
            f = int'($urandom % m);
            period_test(f, m);
        end
        for (int k = 0; k < 3; k++) begin
            int m, f;
            m = 50 + int'($urandom % 4000);
            f = int'($urandom % m);
            do_load(f, m, 1'b1);
            run(1500, "R8");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule